// File: doc/BRIEF.md
# Bit-Serial CRC Divider

This block computes a cyclic redundancy check one bit per clock. Its core is a chain of `WIDTH` flip-flops with feedback from the last stage. Each clock that carries a valid bit divides the bit stream seen so far by a fixed divisor polynomial, in modulo-2 arithmetic. The divisor has degree `WIDTH`. Its leading coefficient is implied, and the parameter `POLY` supplies the lower `WIDTH` coefficients. Bit 0 of `POLY` must be 1.

To build a codeword, the controller selects generate mode, clears the block and shifts in the message most significant bit first. It then shifts in `WIDTH` zero bits. After the last zero, `crc_out` holds the remainder to append to the message. To check a received codeword, the controller selects check mode and shifts in the whole codeword, message followed by its remainder. The strobe on the final bit latches an error flag. The flag is set whenever the remainder left over is nonzero.

Stage 0 is the stage that receives the serial input. After the stream ends, the remainder sits in the stages with its lowest coefficient in stage 0, which is the reverse of its written order. `crc_out` presents the remainder in written order. `crc_raw` presents the stages in their physical order.

Top module: `crc_serial_engine`

## Requirements
- R1: When `rst_n` is low, or when `clr` is high, at a clock edge, every stage and `crc_err` become 0. `clr` takes priority over `bit_vld`.
- R2: On an edge where `bit_vld` is low and `clr` is low, the stages and `crc_err` keep their values, whatever `bit_in` and `bit_last` are.
- R3: After each edge that accepts a bit, `crc_out` equals the remainder of the polynomial formed by all bits accepted since the last clear, first bit highest, divided by x^WIDTH + POLY. Bit k of `crc_out` is the coefficient of x^k.
- R4: With WIDTH=3 and POLY=3'b011 (divisor 1011), the input stream 1001101 followed by 000 gives `crc_raw` = 3'b001 after three bits, 3'b010 after four bits, and `crc_out` = 3'b101 at the end.
- R5: `crc_raw` is `crc_out` with its bit order reversed. Bit WIDTH-1 of `crc_raw` is stage 0.
- R6: In check mode (`chk_mode`=1), an edge with `bit_vld` and `bit_last` both high sets `crc_err` to 1 if the remainder after that bit is nonzero, and to 0 if it is zero. The new value shows after that edge.
- R7: In generate mode (`chk_mode`=0), an accepted last bit sets `crc_err` to 0.
- R8: In check mode, the codeword 1001101101 under divisor 1011 leaves `crc_err` = 0. The same codeword with any single bit inverted leaves `crc_err` = 1. For a 16-bit divisor, a message followed by its own generated remainder leaves `crc_err` = 0.
- R9: Between last-bit strobes, `crc_err` holds its value. Raising `bit_last` while `bit_vld` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear before a new stream |
| bit_vld | input | 1 | Accept `bit_in` on this edge |
| bit_in | input | 1 | Serial data, most significant bit first |
| bit_last | input | 1 | Marks the final bit of the stream |
| chk_mode | input | 1 | 1 = check received codeword, 0 = generate |
| crc_out | output | WIDTH | Remainder, bit k = coefficient of x^k |
| crc_raw | output | WIDTH | Stages in physical order, stage 0 at MSB |
| crc_err | output | 1 | Latched nonzero-remainder flag |

## Verification
The properties assume that `clr`, `bit_vld`, `bit_last` and `chk_mode` are known, never X, at every sampled edge. They assume the same of `bit_in` whenever `bit_vld` is high. They do not assume that the mode stays fixed across a stream, and they do not assume that `bit_last` comes only with `bit_vld`. The stimulus drives every input to a defined level on the falling edge. It toggles `bit_in` and `bit_last` during gaps where `bit_vld` is low, and issues clears both in the middle of a stream and between streams. This shows that the hold and clear properties cover those cases and not only tidy framing.

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             bit_last,
  input  logic             chk_mode,
  output logic [WIDTH-1:0] crc_out,
  output logic [WIDTH-1:0] crc_raw,
  output logic             crc_err
);

  logic [WIDTH-1:0] stg;
  logic [WIDTH-1:0] nxt;
  logic             fb;

  assign fb = stg[WIDTH-1];

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign nxt[k] = bit_in ^ (POLY[k] & fb);
    end else begin : g_body
      assign nxt[k] = stg[k-1] ^ (POLY[k] & fb);
    end
    assign crc_raw[WIDTH-1-k] = stg[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      stg     <= '0;
      crc_err <= 1'b0;
    end else if (bit_vld) begin
      stg <= nxt;
      if (bit_last) crc_err <= chk_mode & (|nxt);
    end
  end

  assign crc_out = stg;

endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY = 16'h1021
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             bit_vld,
  input logic             bit_in,
  input logic             bit_last,
  input logic             chk_mode,
  input logic [WIDTH-1:0] crc_out,
  input logic [WIDTH-1:0] crc_raw,
  input logic             crc_err
);

  logic [WIDTH:0]   step_div;
  logic [WIDTH-1:0] flipped;

  assign step_div = {crc_out, bit_in} ^ (crc_out[WIDTH-1] ? {1'b1, POLY} : '0);

  always_comb begin
    for (int i = 0; i < WIDTH; i++) flipped[i] = crc_out[WIDTH-1-i];
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == '0) && !crc_err);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_vld) |=> $stable(crc_out) && $stable(crc_err));

  p_divide_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld) |=> crc_out == $past(step_div[WIDTH-1:0]));

  p_raw_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_raw == flipped);

  p_check_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && bit_last && chk_mode) |=> crc_err == (crc_out != '0));

  p_gen_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && bit_last && !chk_mode) |=> !crc_err);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(bit_vld && bit_last)) |=> $stable(crc_err));

endmodule

bind crc_serial_engine crc_serial_engine_chk #(.WIDTH(WIDTH), .POLY(POLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
  .bit_last(bit_last), .chk_mode(chk_mode), .crc_out(crc_out),
  .crc_raw(crc_raw), .crc_err(crc_err)
);

// File: tb/sim_crc_serial_engine.sv
module sim_crc_serial_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, bit_last = 1'b0, chk_mode = 1'b0;
  logic [2:0]  o0, r0;
  logic [15:0] o1, r1;
  logic        e0, e1;

  int checks = 0;
  int fails  = 0;

  bit q[$];
  bit m_err0 = 0, m_err1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_serial_engine #(.WIDTH(3), .POLY(3'b011)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_last(bit_last), .chk_mode(chk_mode), .crc_out(o0), .crc_raw(r0), .crc_err(e0));

  crc_serial_engine #(.WIDTH(16), .POLY(16'h1021)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_last(bit_last), .chk_mode(chk_mode), .crc_out(o1), .crc_raw(r1), .crc_err(e1));

  function automatic int unsigned polyrem(int w, int unsigned p);
    int unsigned r = 0;
    foreach (q[i]) begin
      r = (r << 1) | int'(q[i]);
      if (((r >> w) & 1) != 0) r = r ^ ((1 << w) | p);
    end
    return r;
  endfunction

  function automatic int unsigned revbits(int w, int unsigned v);
    int unsigned o = 0;
    for (int i = 0; i < w; i++) if (((v >> i) & 1) != 0) o = o | (1 << (w-1-i));
    return o;
  endfunction

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int unsigned x0 = polyrem(3, 3'b011);
    int unsigned x1 = polyrem(16, 16'h1021);
    chk({tag, " u0 crc_out (R3)"}, o0, x0);
    chk({tag, " u0 crc_raw (R5)"}, r0, revbits(3, x0));
    chk({tag, " u0 crc_err"}, e0, m_err0);
    chk({tag, " u1 crc_out (R3)"}, o1, x1);
    chk({tag, " u1 crc_raw (R5)"}, r1, revbits(16, x1));
    chk({tag, " u1 crc_err"}, e1, m_err1);
  endtask

  task automatic step(bit v, bit b, bit l, bit c, bit m, string tag);
    compare(tag);
    bit_vld = v; bit_in = b; bit_last = l; clr = c; chk_mode = m;
    if (c) begin
      q.delete(); m_err0 = 0; m_err1 = 0;
    end else if (v) begin
      q.push_back(b);
      if (l) begin
        m_err0 = m && (polyrem(3, 3'b011) != 0);
        m_err1 = m && (polyrem(16, 16'h1021) != 0);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic feed(logic [63:0] bits, int n, bit m, string tag);
    for (int i = n-1; i >= 0; i--) step(1, bits[i], i == 0, 0, m, tag);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset crc_out", o0, 0);
    chk("R1 reset crc_err", e0, 0);
    chk("R1 reset u1 crc_out", o1, 0);

    // R4 worked example, generate mode
    step(0, 0, 0, 1, 0, "R1");
    step(1, 1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    chk("R4 raw after three bits", r0, 3'b001);
    step(1, 1, 0, 0, 0, "R4");
    chk("R4 raw after four bits", r0, 3'b010);
    step(1, 1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 1, 0, 0, "R7");
    chk("R4 final remainder", o0, 3'b101);
    chk("R7 generate clears flag", e0, 0);

    // R8 good codeword, then each single-bit error
    step(0, 0, 0, 1, 1, "R1");
    feed(64'b1001101101, 10, 1, "R8");
    compare("R8");
    chk("R8 clean codeword accepted", e0, 0);
    for (int f = 0; f < 10; f++) begin
      step(0, 0, 0, 1, 1, "R1");
      feed(64'b1001101101 ^ (64'd1 << f), 10, 1, "R6");
      compare("R6");
      chk("R8 single-bit error flagged", e0, 1);
    end

    // R2/R9 gaps with noisy bit_in and bit_last while bit_vld is low
    step(1, 1, 0, 0, 1, "R2");
    step(0, 1, 1, 0, 1, "R9");
    step(0, 0, 1, 0, 0, "R9");
    chk("R9 flag held through idle strobe", e0, 1);
    step(1, 0, 0, 0, 1, "R2");
    step(0, 1, 0, 0, 1, "R2");
    // R1 clear in the middle of a stream
    step(0, 0, 0, 1, 1, "R1");
    chk("R1 clear mid stream", o1, 0);
    chk("R1 clear drops flag", e0, 0);
    // R1 clear has priority over a valid bit
    step(1, 1, 1, 1, 1, "R1");
    chk("R1 clear over valid", o0, 0);

    // R8 random messages on the 16-bit divisor: generate, then check
    for (int t = 0; t < 40; t++) begin
      int n = 8 + ($urandom % 40);
      logic [63:0] msg = {$urandom, $urandom};
      int unsigned crc;
      step(0, 0, 0, 1, 0, "R1");
      feed(msg, n, 0, "R3");
      for (int z = 0; z < 16; z++) step(1, 0, z == 15, 0, 0, "R3");
      crc = polyrem(16, 16'h1021);
      compare("R7");
      step(0, 0, 0, 1, 1, "R1");
      feed(msg, n, 1, "R8");
      for (int z = 15; z >= 0; z--) begin
        if ((t % 3) == 0) step(0, $urandom % 2, 1, 0, 1, "R2");
        step(1, crc[z], z == 0, 0, 1, "R8");
      end
      compare("R8");
      chk("R8 16-bit self codeword accepted", e1, 0);
    end

    compare("R3");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule